// File: doc/BRIEF.md
# Queued Byte Output Port with Request/Ready Handshake

This block drives bytes onto an 8-bit parallel bus for an external consumer. A producer writes bytes into an internal queue. The consumer takes them one at a time through a level-sensitive four-phase handshake. The queue absorbs bursts from the producer, so the consumer can pull at its own pace and the port can sustain transfer rates above roughly 10 MHz.

The producer side is a valid/ready stream. A byte is taken on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly while the queue is full. A byte offered while `wr_ready` is low is discarded rather than held. The producer must therefore treat `wr_ready`, or the plain `fifo_full` status pin, as its throttle.

On the consumer side, the consumer raises `req` and the block answers with `rdy`. When `rdy` is high, the byte on `dout` is valid. Both stay frozen until the consumer lowers `req`. The block then drops `rdy` and waits for the next rising `req`. The byte leaves the queue at the moment it is loaded onto `dout`. Everything runs on one clock, with a synchronous active-high reset.

Top module: `byte_out_port`

## Requirements
- R1: While `rst` is high on a rising edge, the queue is emptied and `rdy` and `dout` are cleared to 0. After reset, `wr_ready`=1 and `fifo_full`=0.
- R2: A byte is stored on an edge where `wr_valid` and `wr_ready` are both high. `fifo_full`=1 and `wr_ready`=0 exactly while DEPTH bytes are held.
- R3: A byte offered while the queue is full is discarded. It never appears on `dout`, and the queue contents are unchanged.
- R4: Bytes appear on `dout` in the order they were written, exactly one per completed handshake.
- R5: `req` passes through one register before use. If `req` rises before edge k and the queue is not empty, `rdy` rises with the byte already on `dout` at edge k+1.
- R6: While `rdy` and `req` are both high, `rdy` and `dout` stay stable and no further byte is taken from the queue.
- R7: If `req` falls before edge m, `rdy` falls at edge m+1. A new byte is served only after `req` has been seen low.
- R8: While `req` is high and the queue is empty, `rdy` stays low. If a byte is accepted at edge e, it is loaded and `rdy` rises at edge e+1.
- R9: A byte's queue slot is freed when the byte is loaded onto `dout`. If the queue was full, `wr_ready` is 1 in the same cycle that `rdy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_data | input | 8 | Byte from the producer |
| wr_ready | output | 1 | Queue can accept a byte |
| fifo_full | output | 1 | Queue holds DEPTH bytes |
| req | input | 1 | Consumer request level |
| rdy | output | 1 | Byte on `dout` is valid |
| dout | output | 8 | Parallel output byte |

## Verification
The hardest case to reach is the empty-queue wait. In it, `req` is already high and the byte arrives later, so loading and popping must start from the write rather than from a `req` edge. The bench holds `req` high on an empty queue for several cycles and then writes one byte. A related corner is a pop from a full queue: the bench fills the queue to every level from 1 up to DEPTH+1, which forces the drop case. It then checks `wr_ready` at the cycle where `rdy` rises. Interleaved write and read rounds move the pointers past the wrap point several times.

// File: rtl/bop_pkg.sv
package bop_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_HOLD = 1'b1
  } hs_state_t;
endpackage

// File: rtl/bop_fifo.sv
module bop_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty     = (level == '0);
  assign full      = (level == LVL_W'(DEPTH));
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/bop_req_sync.sv
module bop_req_sync (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_in;
  end
endmodule

// File: rtl/bop_handshake.sv
module bop_handshake
  import bop_pkg::*;
#(
  parameter int WIDTH = BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_q,
  input  logic             q_empty,
  input  logic [WIDTH-1:0] q_head,
  output logic             q_pop,
  output logic             rdy,
  output logic [WIDTH-1:0] dout
);
  hs_state_t state;

  assign q_pop = (state == HS_IDLE) && req_q && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HS_IDLE;
      rdy   <= 1'b0;
      dout  <= '0;
    end else begin
      unique case (state)
        HS_IDLE: if (q_pop) begin
          dout  <= q_head;
          rdy   <= 1'b1;
          state <= HS_HOLD;
        end
        HS_HOLD: if (!req_q) begin
          rdy   <= 1'b0;
          state <= HS_IDLE;
        end
        default: state <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/byte_out_port.sv
module byte_out_port
  import bop_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              fifo_full,
  input  logic              req,
  output logic              rdy,
  output logic [BYTE_W-1:0] dout
);
  logic              req_q;
  logic              push, pop, q_empty;
  logic [BYTE_W-1:0] q_head;
  logic [LVL_W-1:0]  level;

  assign wr_ready = !fifo_full;
  assign push     = wr_valid && wr_ready;

  bop_req_sync u_sync (
    .clk(clk), .rst(rst), .req_in(req), .req_q(req_q)
  );

  bop_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(wr_data), .pop(pop),
    .head_data(q_head), .empty(q_empty), .full(fifo_full), .level(level)
  );

  bop_handshake #(.WIDTH(BYTE_W)) u_hs (
    .clk(clk), .rst(rst), .req_q(req_q), .q_empty(q_empty), .q_head(q_head),
    .q_pop(pop), .rdy(rdy), .dout(dout)
  );
endmodule

// File: rtl/bop_checker.sv
module bop_checker #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_q,
  input logic             rdy,
  input logic [7:0]       dout,
  input logic             pop,
  input logic             full,
  input logic             wr_valid,
  input logic [LVL_W-1:0] level
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rdy && dout == 8'h00 && level == '0));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_valid && !pop) |=> full);

  assert_rise_needs_req_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) |-> $past(req_q));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (rdy && req_q) |=> (rdy && $stable(dout)));

  assert_no_pop_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
    rdy |-> !pop);

  assert_fall_after_release_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy) |-> !$past(req_q));
endmodule

bind byte_out_port bop_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .req_q(req_q), .rdy(rdy), .dout(dout), .pop(pop),
  .full(fifo_full), .wr_valid(wr_valid), .level(level)
);

// File: tb/byte_out_port_bench.sv
`timescale 1ns/1ps
module byte_out_port_bench;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       req = 1'b0;
  logic       wr_ready, fifo_full, rdy;
  logic [7:0] dout;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  byte_out_port #(.DEPTH(DEPTH)) u_byte_out_port (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .fifo_full(fifo_full), .req(req), .rdy(rdy), .dout(dout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 29 + 7) & 8'hFF);
  endfunction

  task automatic put(input logic [7:0] b);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic take(input logic [7:0] exp, input bit from_full);
    req = 1'b1;
    @(negedge clk);
    chk(rdy == 1'b0, "R5 rdy before second edge", rdy, 0);
    @(negedge clk);
    chk(rdy == 1'b1, "R5 rdy on second edge", rdy, 1);
    chk(dout == exp, "R4 byte order", dout, exp);
    if (from_full) chk(wr_ready == 1'b1, "R9 slot freed at load", wr_ready, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rdy == 1'b1 && dout == exp, "R6 hold stable", dout, exp);
    end
    req = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b1, "R7 rdy one edge after drop", rdy, 1);
    @(negedge clk);
    chk(rdy == 1'b0, "R7 rdy falls", rdy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rdy == 1'b0 && dout == 8'h00, "R1 reset outputs", dout, 0);
    chk(wr_ready == 1'b1 && fifo_full == 1'b0, "R1 reset queue empty", fifo_full, 0);

    // R8: request on empty queue, byte arrives later
    req = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(rdy == 1'b0, "R8 wait while empty", rdy, 0);
    end
    put(8'h5A);
    chk(rdy == 1'b0, "R8 not yet loaded", rdy, 0);
    @(negedge clk);
    chk(rdy == 1'b1 && dout == 8'h5A, "R8 loaded after write", dout, 8'h5A);
    req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(rdy == 1'b0, "R7 release after wait", rdy, 0);

    // R2/R3/R4/R9: sweep fill levels including one beyond full
    for (int n = 1; n <= DEPTH + 1; n++) begin
      for (int i = 0; i < n; i++) put(pat(n, i));
      chk(fifo_full == (n >= DEPTH), "R2 full flag", fifo_full, n >= DEPTH);
      chk(wr_ready == (n < DEPTH), "R2 wr_ready", wr_ready, n < DEPTH);
      for (int i = 0; i < ((n > DEPTH) ? DEPTH : n); i++)
        take(pat(n, i), (i == 0) && (n >= DEPTH));
      req = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(rdy == 1'b0, "R3 no extra byte after drain", rdy, 0);
      end
      req = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end

    // R4: interleaved rounds wrap the pointers
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 3; i++) put(pat(40 + r, i));
      for (int i = 0; i < 3; i++) take(pat(40 + r, i), 1'b0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule